// File: doc/BRIEF.md
# Link Lock and Output State Controller

This block sits on the receive side of a serial link and manages link bring-up. It takes the lock and clock-loss indications from an upstream clock-data-recovery stage and brings them into a local control clock domain. It asserts a LOCK status only after the lock indication has stayed steady for a set number of cycles. While the link is unlocked it drives the parallel outputs into a state chosen by a select input. A separate output-enable input can float the outputs at any time.

The block also chooses where the output clock comes from. When the link is locked the output clock is the recovered clock. When the link is unlocked and the oscillator is enabled, the output clock is the internal oscillator clock. Otherwise the output clock is held low. Each source has a two-flop enable handshake in its own clock domain. The handshake turns one source fully off before the other is turned on, so the output clock stays at a steady level during a changeover and never shows a short pulse.

Top module: `link_lock_ctrl`

## Requirements
- R1: While `pwr_en` is low, `lock` is low, and after `pwr_en` has been low at a clock edge `lock` is low from the following cycle on.
- R2: `lock` rises only after `cdr_lock` has been high, with `clk_lost` low, for `STABLE_CYC` consecutive synchronised cycles. Any interruption of that condition restarts the count from zero.
- R3: When `clk_lost` goes high or `cdr_lock` goes low while the link is locked, `lock` falls within four clock cycles.
- R4: When unlocked, with `out_en`=1 and `oss_sel`=0 (drive low), `dout` is all zeros and `dout_oe` is all ones.
- R5: When unlocked, with `out_en`=1 and `oss_sel`=1 (high impedance), `dout_oe` is all zeros.
- R6: When locked, with `out_en`=1, `dout` equals `data_in` and `dout_oe` is all ones, whatever the value of `oss_sel`.
- R7: With `out_en`=0, `dout_oe` is all zeros whether the link is locked or not.
- R8: `clk_out` follows `rec_clk` when locked. It follows `osc_clk` when unlocked with `osc_en`=1. It is held low when unlocked with `osc_en`=0.
- R9: The two source enables are never on at the same time, and during a source switch `clk_out` produces no high or low pulse shorter than the shorter half-period of the two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | High enables the link; low powers it down |
| cdr_lock | input | 1 | Asynchronous lock indication from clock recovery |
| clk_lost | input | 1 | Asynchronous loss-of-incoming-clock indication |
| out_en | input | 1 | High lets the parallel outputs drive; low floats them |
| oss_sel | input | 1 | Unlocked output state: 0 drive low, 1 high impedance |
| osc_en | input | 1 | Offer the oscillator as output clock while unlocked |
| osc_clk | input | 1 | Internal oscillator clock |
| rec_clk | input | 1 | Recovered clock |
| data_in | input | WIDTH | Recovered parallel data |
| lock | output | 1 | Link locked status |
| dout | output | WIDTH | Parallel output data |
| dout_oe | output | WIDTH | Per-bit output enable, 1 = driven |
| clk_out | output | 1 | Selected output clock |

## Verification
The output stage is driven from a vector table that crosses lock status, `out_en` and `oss_sel` with distinct data bytes. This separates the drive-low state from the float state, and shows that locked data passes unchanged whatever the select setting. The lock qualifier is tried with a clean steady lock, with a short dropout in the middle of the count (a counter that does not restart would show up here), with clock loss, and with power-down. The output clock is measured by counting edges over a fixed window for the recovered, oscillator and disabled cases, which tells the two source frequencies apart from a stuck clock. Every pulse width on `clk_out` is timed across repeated switches in both directions to detect glitches.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
    typedef enum logic [1:0] {
        ST_DOWN   = 2'd0,
        ST_ACQ    = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

    typedef enum logic {
        OSS_LOW = 1'b0,
        OSS_HIZ = 1'b1
    } oss_mode_e;

    localparam int unsigned N_SRC   = 2;
    localparam int unsigned SRC_OSC = 0;
    localparam int unsigned SRC_REC = 1;

    function automatic logic link_good(input logic lk, input logic lost);
        return lk & ~lost;
    endfunction
endpackage

// File: rtl/lnk_sync.sv
`timescale 1ns/1ps
module lnk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lnk_lock_fsm.sv
`timescale 1ns/1ps
module lnk_lock_fsm
    import lnk_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_en,
    input  logic lock_s,
    input  logic lost_s,
    output logic lock
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    lock_state_e state;
    logic [CW-1:0] cnt;
    logic good;

    assign good = link_good(lock_s, lost_s);

    always_ff @(posedge clk) begin
        if (rst || !pwr_en) begin
            state <= ST_DOWN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_DOWN: begin
                    state <= ST_ACQ;
                    cnt   <= '0;
                end
                ST_ACQ: begin
                    if (!good) begin
                        cnt <= '0;
                    end else if (cnt == LAST) begin
                        state <= ST_LOCKED;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (!good) begin
                        state <= ST_ACQ;
                        cnt   <= '0;
                    end
                end
                default: begin
                    state <= ST_DOWN;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign lock = (state == ST_LOCKED);
endmodule

// File: rtl/lnk_out_stage.sv
`timescale 1ns/1ps
module lnk_out_stage
    import lnk_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             lock,
    input  logic             out_en,
    input  oss_mode_e        oss,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dout_oe
);
    typedef struct packed {
        logic [WIDTH-1:0] d;
        logic [WIDTH-1:0] oe;
    } pins_t;

    pins_t pins;

    always_comb begin
        if (lock) begin
            pins.d  = data_in;
            pins.oe = '1;
        end else if (oss == OSS_LOW) begin
            pins.d  = '0;
            pins.oe = '1;
        end else begin
            pins.d  = '0;
            pins.oe = '0;
        end
        if (!out_en) pins.oe = '0;
    end

    assign dout    = pins.d;
    assign dout_oe = pins.oe;
endmodule

// File: rtl/lnk_clk_switch.sv
`timescale 1ns/1ps
module lnk_clk_leg (
    input  logic src_clk,
    input  logic rst,
    input  logic want,
    input  logic other_en,
    output logic en
);
    logic stg;

    always_ff @(negedge src_clk) begin
        if (rst) begin
            stg <= 1'b0;
            en  <= 1'b0;
        end else begin
            stg <= want & ~other_en;
            en  <= stg;
        end
    end
endmodule

module lnk_clk_switch
    import lnk_pkg::*;
(
    input  logic rst,
    input  logic lock,
    input  logic osc_en,
    input  logic osc_clk,
    input  logic rec_clk,
    output logic en_osc,
    output logic en_rec,
    output logic clk_out
);
    logic [N_SRC-1:0] src;
    logic [N_SRC-1:0] want;
    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] gated;

    assign src[SRC_OSC]  = osc_clk;
    assign src[SRC_REC]  = rec_clk;
    assign want[SRC_OSC] = ~lock & osc_en;
    assign want[SRC_REC] = lock;

    for (genvar g = 0; g < N_SRC; g++) begin : g_leg
        lnk_clk_leg u_leg (
            .src_clk (src[g]),
            .rst     (rst),
            .want    (want[g]),
            .other_en(en[N_SRC-1-g]),
            .en      (en[g])
        );
        assign gated[g] = src[g] & en[g];
    end

    assign clk_out = |gated;
    assign en_osc  = en[SRC_OSC];
    assign en_rec  = en[SRC_REC];
endmodule

// File: rtl/link_lock_ctrl.sv
`timescale 1ns/1ps
module link_lock_ctrl
    import lnk_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned STABLE_CYC  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_en,
    input  logic             cdr_lock,
    input  logic             clk_lost,
    input  logic             out_en,
    input  logic             oss_sel,
    input  logic             osc_en,
    input  logic             osc_clk,
    input  logic             rec_clk,
    input  logic [WIDTH-1:0] data_in,
    output logic             lock,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dout_oe,
    output logic             clk_out
);
    logic lock_s, lost_s;
    logic en_osc, en_rec;

    lnk_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
        .clk(clk), .rst(rst), .d(cdr_lock), .q(lock_s)
    );
    lnk_sync #(.STAGES(SYNC_STAGES)) u_sync_lost (
        .clk(clk), .rst(rst), .d(clk_lost), .q(lost_s)
    );

    lnk_lock_fsm #(.STABLE_CYC(STABLE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .pwr_en(pwr_en),
        .lock_s(lock_s), .lost_s(lost_s), .lock(lock)
    );

    lnk_out_stage #(.WIDTH(WIDTH)) u_out (
        .lock(lock), .out_en(out_en), .oss(oss_mode_e'(oss_sel)),
        .data_in(data_in), .dout(dout), .dout_oe(dout_oe)
    );

    lnk_clk_switch u_cksw (
        .rst(rst), .lock(lock), .osc_en(osc_en),
        .osc_clk(osc_clk), .rec_clk(rec_clk),
        .en_osc(en_osc), .en_rec(en_rec), .clk_out(clk_out)
    );
endmodule

// File: rtl/lnk_checker.sv
`timescale 1ns/1ps
module lnk_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_en,
    input logic             out_en,
    input logic             oss_sel,
    input logic             lock,
    input logic [WIDTH-1:0] data_in,
    input logic [WIDTH-1:0] dout,
    input logic [WIDTH-1:0] dout_oe,
    input logic             en_osc,
    input logic             en_rec
);
    assert_pwrdn_unlock_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !lock);

    assert_rise_needs_power_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(pwr_en));

    assert_drive_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!lock && out_en && !oss_sel) |-> (dout == '0 && &dout_oe));

    assert_float_R5: assert property (@(posedge clk) disable iff (rst)
        (!lock && out_en && oss_sel) |-> (dout_oe == '0));

    assert_pass_data_R6: assert property (@(posedge clk) disable iff (rst)
        (lock && out_en) |-> (dout == data_in && &dout_oe));

    assert_oe_off_R7: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (dout_oe == '0));

    assert_one_source_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_osc, en_rec}));
endmodule

bind link_lock_ctrl lnk_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .out_en(out_en),
    .oss_sel(oss_sel), .lock(lock), .data_in(data_in), .dout(dout),
    .dout_oe(dout_oe), .en_osc(en_osc), .en_rec(en_rec)
);

// File: tb/sim_link_lock_ctrl.sv
`timescale 1ns/1ps
module sim_link_lock_ctrl;
    localparam int unsigned W      = 8;
    localparam int unsigned STABLE = 16;

    logic clk = 1'b0, osc_clk = 1'b0, rec_clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_en = 1'b0, cdr_lock = 1'b0, clk_lost = 1'b0;
    logic out_en = 1'b1, oss_sel = 1'b0, osc_en = 1'b0;
    logic [W-1:0] data_in = '0;
    logic lock, clk_out;
    logic [W-1:0] dout, dout_oe;

    always #2.5 clk = ~clk;
    always #7.0 osc_clk = ~osc_clk;
    always #3.0 rec_clk = ~rec_clk;

    link_lock_ctrl #(.WIDTH(W), .STABLE_CYC(STABLE)) u0 (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .cdr_lock(cdr_lock),
        .clk_lost(clk_lost), .out_en(out_en), .oss_sel(oss_sel),
        .osc_en(osc_en), .osc_clk(osc_clk), .rec_clk(rec_clk),
        .data_in(data_in), .lock(lock), .dout(dout), .dout_oe(dout_oe),
        .clk_out(clk_out)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // clk_out pulse monitor
    int   edges = 0;
    int   short_pulses = 0;
    realtime last_edge = 0.0;
    always @(posedge clk_out) edges++;
    always @(clk_out) begin
        if (!rst && ($realtime - last_edge) < 2.9) short_pulses++;
        last_edge = $realtime;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_edges(output int n);
        int start;
        start = edges;
        #300;
        n = edges - start;
    endtask

    task automatic set_link(input logic lk);
        cdr_lock = lk;
        cycles(lk ? STABLE + 6 : 6);
    endtask

    typedef struct packed {
        logic         lk;
        logic         oe_in;
        logic         oss;
        logic [W-1:0] data;
        logic [W-1:0] exp_d;
        logic [W-1:0] exp_oe;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b1, 1'b0, 8'hA5, 8'h00, 8'hFF},  // R4
        '{1'b0, 1'b1, 1'b1, 8'h3C, 8'h00, 8'h00},  // R5
        '{1'b0, 1'b0, 1'b0, 8'h5A, 8'h00, 8'h00},  // R7 unlocked
        '{1'b1, 1'b1, 1'b0, 8'hC3, 8'hC3, 8'hFF},  // R6
        '{1'b1, 1'b1, 1'b1, 8'h7E, 8'h7E, 8'hFF},  // R6 with oss=1
        '{1'b1, 1'b0, 1'b1, 8'h81, 8'h00, 8'h00}   // R7 locked
    };

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        cycles(20);
        rst = 1'b0;
        cycles(2);
        // R1 reset / power-down state
        check(lock == 1'b0, "R1 reset lock", 32'(lock), 0);
        cdr_lock = 1'b1;
        cycles(STABLE + 8);
        check(lock == 1'b0, "R1 lock held low while powered down", 32'(lock), 0);
        pwr_en = 1'b1;
        cycles(STABLE + 8);
        check(lock == 1'b1, "R2 lock after bring-up", 32'(lock), 1);
        set_link(1'b0);

        // table walk: output stage
        for (int i = 0; i < 6; i++) begin
            if (lock != VEC[i].lk) set_link(VEC[i].lk);
            out_en  = VEC[i].oe_in;
            oss_sel = VEC[i].oss;
            data_in = VEC[i].data;
            cycles(1);
            check(dout_oe == VEC[i].exp_oe, "R4/R5/R6/R7 dout_oe", 32'(dout_oe), 32'(VEC[i].exp_oe));
            if (VEC[i].exp_oe != '0)
                check(dout == VEC[i].exp_d, "R4/R6 dout", 32'(dout), 32'(VEC[i].exp_d));
        end
        out_en = 1'b1;
        oss_sel = 1'b0;
        set_link(1'b0);

        // R2 exact qualification window
        cdr_lock = 1'b1;
        cycles(STABLE);
        check(lock == 1'b0, "R2 not yet locked", 32'(lock), 0);
        cycles(3);
        check(lock == 1'b1, "R2 locked after window", 32'(lock), 1);
        set_link(1'b0);

        // R2 interruption restarts count
        cdr_lock = 1'b1;
        cycles(STABLE / 2);
        cdr_lock = 1'b0;
        cycles(3);
        cdr_lock = 1'b1;
        cycles(STABLE);
        check(lock == 1'b0, "R2 dropout restarts count", 32'(lock), 0);
        cycles(3);
        check(lock == 1'b1, "R2 locked after restart", 32'(lock), 1);

        // R3 clock loss
        clk_lost = 1'b1;
        cycles(4);
        check(lock == 1'b0, "R3 clock loss unlocks", 32'(lock), 0);
        cycles(1);
        check(dout_oe == 8'hFF && dout == 8'h00, "R3 outputs back to oss state", 32'(dout), 0);
        clk_lost = 1'b0;
        cycles(STABLE + 6);
        check(lock == 1'b1, "R3 relock after clock return", 32'(lock), 1);
        cdr_lock = 1'b0;
        cycles(4);
        check(lock == 1'b0, "R3 lock drop unlocks", 32'(lock), 0);

        // R1 power-down from locked
        set_link(1'b1);
        pwr_en = 1'b0;
        cycles(2);
        check(lock == 1'b0, "R1 power-down unlocks", 32'(lock), 0);
        pwr_en = 1'b1;
        cycles(STABLE + 6);

        // R8 clock source selection
        #100;
        count_edges(n);
        check(n >= 45 && n <= 55, "R8 recovered clock when locked", 32'(n), 50);
        set_link(1'b0);
        osc_en = 1'b0;
        #100;
        count_edges(n);
        check(n == 0, "R8 held low with oscillator disabled", 32'(n), 0);
        check(clk_out == 1'b0, "R8 held level low", 32'(clk_out), 0);
        osc_en = 1'b1;
        #100;
        count_edges(n);
        check(n >= 19 && n <= 23, "R8 oscillator clock when unlocked", 32'(n), 21);

        // R9 repeated switching in both directions
        for (int k = 0; k < 4; k++) begin
            set_link(1'b1);
            #37;
            set_link(1'b0);
            #23;
        end
        check(short_pulses == 0, "R9 no short pulse on clk_out", 32'(short_pulses), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule